// File: doc/BRIEF.md
# Double-Buffered Segment Display Data Update

This block holds the pixel pattern for a segment LCD controller in two layers. Software writes a staging bank of 32-bit words through a simple indexed write port. It then raises an update request. The hardware copies the whole staging bank into the display-side buffer in one clock edge. That copy waits for a safe point: while the controller runs, it happens on a frame-boundary strobe, so a frame never shows a mix of old and new segments.

Completion is reported with a sticky done flag. The done flag drives an interrupt when software has enabled it. While a request is outstanding the staging bank is frozen, so the snapshot that will be shown is exactly what software wrote before the request. When the controller is switched off there is no frame to protect, and the copy happens at once. Scanning the display buffer onto the pads is handled elsewhere.

Top module: `segbuf_dbl_update`

## Requirements
- R1: After reset every display word, the pending flag, the done flag and the interrupt are 0.
- R2: A write with `wr_en` high stores `wr_data` into staging word `wr_idx` (0 to 7). After a copy, staging word i appears at `disp_data[32*i+31:32*i]`.
- R3: A cycle with `upd_req` high makes `req_pending` 1 from the next cycle on. The flag stays 1 until a copy takes place.
- R4: With `ctrl_on` high, a copy happens only at the clock edge of a cycle where `req_pending` and `frame_tick` are both high. At that edge the display takes the staging bank, `req_pending` clears and `done_flag` sets.
- R5: With `ctrl_on` low, a pending request copies at the first clock edge on which it is pending, with no frame strobe needed.
- R6: Staging writes in a cycle where `req_pending` is 1 are ignored. A write in the same cycle as `upd_req`, made while nothing is pending, is accepted and becomes part of the snapshot.
- R7: `done_clr` high clears `done_flag` at the next edge. If a copy falls in the same cycle, the done flag stays set.
- R8: `upd_irq` is 1 exactly when `done_flag` and `irq_en` are both 1.
- R9: A new request made while `done_flag` is 1 leaves `done_flag` at 1 until software clears it.
- R10: A request in the same cycle as a copy keeps `req_pending` at 1, which queues a further transfer.
- R11: `disp_data` changes only at a copy edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging word write strobe |
| wr_idx | input | 3 | Staging word index |
| wr_data | input | 32 | Staging word data |
| upd_req | input | 1 | Update request write (set request bit) |
| frame_tick | input | 1 | Frame-boundary strobe |
| ctrl_on | input | 1 | Controller running |
| done_clr | input | 1 | Write-1-to-clear of the done flag |
| irq_en | input | 1 | Update-done interrupt enable |
| disp_data | output | 256 | Display buffer, word i in bits 32i+31..32i |
| req_pending | output | 1 | Update request outstanding |
| done_flag | output | 1 | Update done (sticky) |
| upd_irq | output | 1 | Update-done interrupt |

## Verification
Two pairs of functions can fall in the same cycle. A copy can meet a software clear of the done flag, and a copy can meet a fresh update request. The bench provokes both pairs on purpose by raising `frame_tick` together with `done_clr`, and in a separate step together with `upd_req`. It judges the result by the done flag surviving the clear and by the pending flag staying set while the display takes the new data. A behavioural model, stepped on every edge under both directed and random stimulus, also catches any other coincidence of write, request, strobe and clear.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  typedef struct packed {
    logic pend;
    logic done;
  } upd_state_t;
endpackage

// File: rtl/segbuf_stage.sv
module segbuf_stage #(
  parameter int NWORDS = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     lock,
  output logic [NWORDS*WORD_W-1:0] stage_q
);
  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic              we;
    logic [WORD_W-1:0] word_d;

    always_comb begin
      we     = wr_en && !lock && (wr_idx == IDX_W'(gi));
      word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stage_q[gi*WORD_W +: WORD_W] <= '0;
      else if (we) stage_q[gi*WORD_W +: WORD_W] <= word_d;
    end
  end

  // R6: a frozen bank keeps its contents
  p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(stage_q));
endmodule

// File: rtl/segbuf_display.sv
module segbuf_display #(
  parameter int NWORDS = 8,
  parameter int WORD_W = 32,
  localparam int TOT_W = NWORDS * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copy,
  input  logic [TOT_W-1:0] stage_in,
  output logic [TOT_W-1:0] disp_q
);
  logic [TOT_W-1:0] disp_d;

  always_comb begin
    disp_d = stage_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    disp_q <= '0;
    else if (copy) disp_q <= disp_d;
  end
endmodule

// File: rtl/segbuf_ctrl.sv
module segbuf_ctrl
  import segbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req,
  input  logic frame_tick,
  input  logic ctrl_on,
  input  logic done_clr,
  input  logic irq_en,
  output logic pending,
  output logic done,
  output logic copy,
  output logic irq
);
  upd_state_t st_q, st_d;

  always_comb begin
    copy      = st_q.pend && (frame_tick || !ctrl_on);
    st_d.pend = (st_q.pend && !copy) || upd_req;
    st_d.done = copy || (st_q.done && !done_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_comb begin
    pending = st_q.pend;
    done    = st_q.done;
    irq     = st_q.done && irq_en;
  end

  // R4: no copy in the middle of a running frame
  p_hold_midframe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pending && ctrl_on && !frame_tick |=> pending);
  // R4: the request retiring comes with done set
  p_done_on_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> done);
  // R7: a clear without a copy empties the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr && !copy |=> !done);
  // R9: done is sticky without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_clr |=> done);
endmodule

// File: rtl/segbuf_dbl_update.sv
module segbuf_dbl_update #(
  parameter int NWORDS = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     upd_req,
  input  logic                     frame_tick,
  input  logic                     ctrl_on,
  input  logic                     done_clr,
  input  logic                     irq_en,
  output logic [NWORDS*WORD_W-1:0] disp_data,
  output logic                     req_pending,
  output logic                     done_flag,
  output logic                     upd_irq
);
  logic [NWORDS*WORD_W-1:0] stage_w;
  logic                     copy_w;

  segbuf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .frame_tick(frame_tick),
    .ctrl_on(ctrl_on), .done_clr(done_clr), .irq_en(irq_en),
    .pending(req_pending), .done(done_flag), .copy(copy_w), .irq(upd_irq)
  );

  segbuf_stage #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .lock(req_pending), .stage_q(stage_w)
  );

  segbuf_display #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .copy(copy_w), .stage_in(stage_w),
    .disp_q(disp_data)
  );

  // R11: the visible image moves only when a request was outstanding
  p_disp_only_on_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_data) |-> $past(req_pending));
endmodule

// File: tb/segbuf_dbl_update_bench.sv
module segbuf_dbl_update_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0;
  logic [2:0]   wr_idx = 0;
  logic [31:0]  wr_data = 0;
  logic         upd_req = 0, frame_tick = 0, ctrl_on = 0, done_clr = 0, irq_en = 0;
  logic [255:0] disp_data;
  logic         req_pending, done_flag, upd_irq;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  segbuf_dbl_update u_segbuf_dbl_update (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_req(upd_req), .frame_tick(frame_tick), .ctrl_on(ctrl_on),
    .done_clr(done_clr), .irq_en(irq_en), .disp_data(disp_data),
    .req_pending(req_pending), .done_flag(done_flag), .upd_irq(upd_irq)
  );

  // behavioural reference model
  logic [31:0] m_stg [8];
  logic [31:0] m_disp[8];
  bit m_pend, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_stg[i] = 0; m_disp[i] = 0; end
      m_pend = 0; m_done = 0;
    end else begin
      bit cp;
      cp = m_pend && (frame_tick || !ctrl_on);
      if (cp) for (int i = 0; i < 8; i++) m_disp[i] = m_stg[i];
      if (wr_en && !m_pend) m_stg[wr_idx] = wr_data;
      m_pend = (m_pend && !cp) || upd_req;
      m_done = cp || (m_done && !done_clr);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R11 covers the image, R8 the interrupt)
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 8; i++)
      if (disp_data[i*32 +: 32] !== m_disp[i]) chk(0, "R11 model word", disp_data[i*32 +: 32], m_disp[i]);
    chk(req_pending === m_pend, "R3 model pending", 32'(req_pending), 32'(m_pend));
    chk(done_flag === m_done, "R7 model done", 32'(done_flag), 32'(m_done));
    chk(upd_irq === (m_done && irq_en), "R8 model irq", 32'(upd_irq), 32'(m_done && irq_en));
  end

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_en = 1; wr_idx = 3'(idx); wr_data = d; cyc(); wr_en = 0;
  endtask

  function automatic logic [31:0] dw(input int i);
    return disp_data[i*32 +: 32];
  endfunction

  initial begin : watchdog
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    chk(dw(0) == 0 && dw(7) == 0, "R1 display zero", dw(0), 0);
    chk(!req_pending && !done_flag && !upd_irq, "R1 flags zero", {req_pending, done_flag, upd_irq}, 0);
    rst_n = 1; cyc();

    ctrl_on = 1;
    for (int i = 0; i < 8; i++) wr(i, 32'hA000_0000 + i);
    chk(dw(3) == 0, "R11 no copy without request", dw(3), 0);
    upd_req = 1; cyc(); upd_req = 0;
    chk(req_pending, "R3 pending set", req_pending, 1);
    cyc(3);
    chk(req_pending && dw(3) == 0, "R4 waits for frame strobe", dw(3), 0);
    wr(3, 32'hDEAD_BEEF);
    frame_tick = 1; cyc(); frame_tick = 0;
    chk(dw(3) == 32'hA000_0003, "R6 locked write ignored", dw(3), 32'hA000_0003);
    chk(dw(7) == 32'hA000_0007, "R2 word placement", dw(7), 32'hA000_0007);
    chk(!req_pending && done_flag, "R4 copy retires request", {req_pending, done_flag}, 1);
    chk(!upd_irq, "R8 irq masked", upd_irq, 0);
    irq_en = 1; #1;
    chk(upd_irq, "R8 irq enabled", upd_irq, 1);
    cyc();

    wr(0, 32'h1111_0000);
    wr_en = 1; wr_idx = 1; wr_data = 32'h2222_0001; upd_req = 1; cyc(); wr_en = 0; upd_req = 0;
    chk(req_pending && done_flag, "R9 done kept on new request", {req_pending, done_flag}, 3);
    frame_tick = 1; done_clr = 1; cyc(); frame_tick = 0; done_clr = 0;
    chk(done_flag, "R7 copy beats clear", done_flag, 1);
    chk(dw(1) == 32'h2222_0001, "R6 same-cycle write joins snapshot", dw(1), 32'h2222_0001);
    done_clr = 1; cyc(); done_clr = 0;
    chk(!done_flag && !upd_irq, "R7 clear", done_flag, 0);

    ctrl_on = 0;
    wr(5, 32'h5555_5555);
    upd_req = 1; cyc(); upd_req = 0;
    chk(req_pending && dw(5) == 32'hA000_0005, "R5 pending one cycle", dw(5), 32'hA000_0005);
    cyc();
    chk(!req_pending && done_flag && dw(5) == 32'h5555_5555, "R5 immediate copy", dw(5), 32'h5555_5555);

    ctrl_on = 1;
    upd_req = 1; cyc(); upd_req = 0;
    frame_tick = 1; upd_req = 1; cyc(); frame_tick = 0; upd_req = 0;
    chk(req_pending, "R10 request queued at copy", req_pending, 1);
    frame_tick = 1; cyc(); frame_tick = 0;
    chk(!req_pending, "R10 queued request retires", req_pending, 0);

    for (int k = 0; k < 2000; k++) begin
      wr_en = $urandom_range(0, 1); wr_idx = 3'($urandom); wr_data = $urandom;
      upd_req = ($urandom_range(0, 7) == 0); frame_tick = ($urandom_range(0, 5) == 0);
      ctrl_on = ($urandom_range(0, 9) != 0); done_clr = ($urandom_range(0, 5) == 0);
      irq_en = $urandom_range(0, 1);
      cyc();
    end
    wr_en = 0; upd_req = 0; frame_tick = 0; done_clr = 0;
    cyc(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule